// File: doc/BRIEF.md
# Dual-Width SPI Master/Slave Port

This block is a serial peripheral port that either generates the serial clock itself (master role) or follows a clock arriving on a pin (slave role). Words are 8 or 16 bits long, most significant bit first. Outgoing and incoming bits share one shift register. A transmit holding buffer feeds that register and a receive holding buffer takes the finished words. The serial clock idles low. Data changes after a falling edge and is sampled on the rising edge.

Software uses two addresses. At the data address, a write fills the transmit buffer and a read takes the oldest received word. The control/status address holds the role, the slave-select enable and the word length. It also shows the receive-full, transmit-empty and overflow flags. Any change of word length clears the transfer in progress, so software should change it only between transfers. In the master role, the clock runs at the system clock divided by the even parameter `CLK_DIV`. In the slave role, the clock, select and data pins pass through a two-stage synchronizer before use.

Top module: `spiDualWidth`

## Requirements
- R1: After reset the status read (address 1) is 0x0200. That means the transmit-empty flag (bit 9) is set, receive-full (bit 8) and overflow (bit 10) are clear, and the control bits are 0, which selects slave role, 8-bit words and select disabled.
- R2: Transmission is MSB first. In 8-bit mode the word leaves from shift-register bit 7, so bits 15..8 of the written value never appear. In 16-bit mode it leaves from bit 15.
- R3: One word uses exactly 8 serial clock pulses in 8-bit mode (control bit 2 = 0) and 16 pulses in 16-bit mode (bit 2 = 1). Incoming bits enter at bit 0. In 8-bit mode the received word is zero-extended to 16 bits.
- R4: With control bit 0 set, the block is master. It drives `sckOut` with `sckOe` high, and the clock stays high for `CLK_DIV/2` system cycles of each pulse. With bit 0 clear, `sckOe` is low and the block follows `sckIn`.
- R5: The serial clock idles low. `sdo` never changes at the system edge where the master clock rises.
- R6: A write to address 0 loads the transmit buffer. A read from address 0 returns the receive buffer.
- R7: A word is taken from the transmit buffer when a transfer starts, and transmit-empty is then set. When a word completes, receive-full is set. A read from address 0 clears receive-full and overflow.
- R8: If a word completes while receive-full is still set, overflow (status bit 10) is set and the receive buffer keeps its earlier word.
- R9: In slave role with select enabled (control bit 1 = 1), `ssN` high turns `sdoOe` off, holds the bit counter at zero and lets clock pulses pass with no effect. With `ssN` low the transfers proceed normally.
- R10: In slave role with select disabled, the block transfers on clock pulses alone, whatever level `ssN` has, and `sdoOe` stays high.
- R11: A control write that changes bit 2 clears the transfer state. The bit counter returns to zero, the shift register is cleared, transmit-empty is set, and receive-full and overflow are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (address 0 read pops receive state) |
| busAddr | input | 1 | 0 = data buffers, 1 = control/status |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data |
| sckIn | input | 1 | Serial clock from pin (slave role) |
| sckOut | output | 1 | Generated serial clock (master role) |
| sckOe | output | 1 | Output enable for the serial clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Output enable for the serial data pin |
| ssN | input | 1 | Active-low slave select |

## Verification
The bench sends words in both widths and both roles, and a scoreboard compares each serial word against the value written. A design that sent from the wrong bit, or used the wrong pulse count, would fail the scoreboard or leave a partial count behind. One test lets a second word arrive before the first is read; a design that overwrote the buffer would return the newer word. Other tests send clock pulses while select is inactive, and change the word length partway through a word. A design that counted those pulses, or kept its bit position after the length change, would receive a shifted word in the next full transfer.

// File: rtl/spiPortPkg.sv
`timescale 1ns/1ps
package spiPortPkg;
  localparam int CTL_MASTER  = 0;
  localparam int CTL_SSEN    = 1;
  localparam int CTL_WIDE    = 2;
  localparam int CTL_BITS    = 3;
  localparam int ST_RXFULL   = 8;
  localparam int ST_TXEMPTY  = 9;
  localparam int ST_OVERFLOW = 10;

  typedef struct packed {
    logic load;    // transmit buffer -> shift register
    logic sample;  // capture serial input bit
    logic shift;   // advance shift register
    logic done;    // final shift of a word
    logic flush;   // word-length change
  } spiStrobe_t;
endpackage

// File: rtl/spiSync.sv
`timescale 1ns/1ps
module spiSync #(
  parameter int STAGES = 2,
  parameter int W = 1,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= RESET_VAL;
          else       chain[0] <= dIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[g] <= RESET_VAL;
          else       chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/spiCtrl.sv
`timescale 1ns/1ps
module spiCtrl
  import spiPortPkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int WIDE_W = 16,
  parameter int NARROW_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctlWrEn,
  input  logic [CTL_BITS-1:0] ctlWrData,
  input  logic                txEmpty,
  input  logic                sckIn,
  input  logic                sdi,
  input  logic                ssN,
  output spiStrobe_t          strobe,
  output logic                rxBit,
  output logic                sckOut,
  output logic                sckOe,
  output logic                sdoOe,
  output logic [CTL_BITS-1:0] ctlBits
);
  localparam int HALF  = (CLK_DIV / 2 < 1) ? 1 : CLK_DIV / 2;
  localparam int HCW   = $clog2(HALF + 1);
  localparam int CNT_W = $clog2(WIDE_W + 1);

  logic masterEn, ssEn, wide;
  logic [2:0] pinSync;
  logic sckPrev;
  logic running;
  logic [HCW-1:0] halfCnt;
  logic [CNT_W-1:0] bitCnt, wordLen;
  logic ssInactive, slaveActive, tick, sRise, sFall;
  logic sampleW, shiftW, doneW, flushW, loadW;

  spiSync #(.STAGES(SYNC_STAGES), .W(3), .RESET_VAL(3'b010)) uSync (
    .clk(clk), .rstN(rstN), .dIn({sdi, ssN, sckIn}), .dOut(pinSync)
  );

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterEn <= 1'b0;
      ssEn     <= 1'b0;
      wide     <= 1'b0;
    end else if (ctlWrEn) begin
      masterEn <= ctlWrData[CTL_MASTER];
      ssEn     <= ctlWrData[CTL_SSEN];
      wide     <= ctlWrData[CTL_WIDE];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= pinSync[0];
  end

  always_comb begin
    wordLen     = wide ? CNT_W'(WIDE_W) : CNT_W'(NARROW_W);
    ssInactive  = ssEn && pinSync[1];
    slaveActive = !masterEn && !ssInactive;
    sRise       = pinSync[0] && !sckPrev;
    sFall       = !pinSync[0] && sckPrev;
    tick        = masterEn && running && (halfCnt == HCW'(HALF - 1));
    flushW      = ctlWrEn && (ctlWrData[CTL_WIDE] != wide);
    sampleW     = !flushW && (masterEn ? (tick && !sckOut) : (slaveActive && sRise));
    shiftW      = !flushW && (bitCnt != '0) &&
                  (masterEn ? (tick && sckOut) : (slaveActive && sFall));
    doneW       = shiftW && (bitCnt == wordLen);
    loadW       = !flushW && (bitCnt == '0) && !txEmpty && !sampleW &&
                  (masterEn ? !running : slaveActive);
    rxBit       = masterEn ? sdi : pinSync[2];
  end

  assign strobe.load   = loadW;
  assign strobe.sample = sampleW;
  assign strobe.shift  = shiftW;
  assign strobe.done   = doneW;
  assign strobe.flush  = flushW;

  // bit counter: counts rising edges within a word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  bitCnt <= '0;
    else if (flushW || doneW)                   bitCnt <= '0;
    else if (!masterEn && ssInactive)           bitCnt <= '0;
    else if (sampleW)                           bitCnt <= bitCnt + 1'b1;
  end

  // master clock generator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      sckOut  <= 1'b0;
      halfCnt <= '0;
    end else if (flushW) begin
      running <= 1'b0;
      sckOut  <= 1'b0;
      halfCnt <= '0;
    end else begin
      if (doneW)                    running <= 1'b0;
      else if (loadW && masterEn)   running <= 1'b1;
      if (tick)                     sckOut <= !sckOut;
      if (!running || tick)         halfCnt <= '0;
      else                          halfCnt <= halfCnt + 1'b1;
    end
  end

  assign sckOe   = masterEn;
  assign sdoOe   = masterEn || !ssInactive;
  assign ctlBits = {wide, ssEn, masterEn};

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= wordLen); // R3
  AST_SS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!masterEn && ssInactive) |=> (bitCnt == '0)); // R9
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (masterEn && !running) |-> !sckOut); // R5
  AST_WIDTH_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    flushW |=> (bitCnt == '0) && !running); // R11
endmodule

// File: rtl/spiDatapath.sv
`timescale 1ns/1ps
module spiDatapath
  import spiPortPkg::*;
#(
  parameter int WIDE_W = 16,
  parameter int NARROW_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  spiStrobe_t          strobe,
  input  logic                rxBit,
  input  logic [CTL_BITS-1:0] ctlBits,
  input  logic                dataWrEn,
  input  logic                dataRdEn,
  input  logic                busAddr,
  input  logic [WIDE_W-1:0]   busWrData,
  output logic [WIDE_W-1:0]   busRdData,
  output logic                sdo,
  output logic                txEmpty
);
  logic [WIDE_W-1:0] txBuf, shiftReg, rxBuf, nextSr, rxWord, statusWord;
  logic rxFull, overflow, rxBitLat, rxFullEff;
  logic wide;

  assign wide      = ctlBits[CTL_WIDE];
  assign nextSr    = {shiftReg[WIDE_W-2:0], rxBitLat};
  assign rxWord    = wide ? nextSr : {{(WIDE_W-NARROW_W){1'b0}}, nextSr[NARROW_W-1:0]};
  assign rxFullEff = rxFull && !dataRdEn;
  assign sdo       = wide ? shiftReg[WIDE_W-1] : shiftReg[NARROW_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf    <= '0;
      shiftReg <= '0;
      rxBitLat <= 1'b0;
      txEmpty  <= 1'b1;
    end else if (strobe.flush) begin
      shiftReg <= '0;
      rxBitLat <= 1'b0;
      txEmpty  <= 1'b1;
    end else begin
      if (strobe.sample) rxBitLat <= rxBit;
      if (strobe.load) begin
        shiftReg <= txBuf;
        txEmpty  <= 1'b1;
      end else if (strobe.shift) begin
        shiftReg <= nextSr;
      end
      if (dataWrEn) begin
        txBuf   <= busWrData;
        txEmpty <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf    <= '0;
      rxFull   <= 1'b0;
      overflow <= 1'b0;
    end else if (strobe.flush) begin
      rxFull   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (dataRdEn) begin
        rxFull   <= 1'b0;
        overflow <= 1'b0;
      end
      if (strobe.done) begin
        if (rxFullEff) begin
          overflow <= 1'b1;
        end else begin
          rxBuf  <= rxWord;
          rxFull <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[CTL_BITS-1:0] = ctlBits;
    statusWord[ST_RXFULL]    = rxFull;
    statusWord[ST_TXEMPTY]   = txEmpty;
    statusWord[ST_OVERFLOW]  = overflow;
    busRdData = busAddr ? statusWord : rxBuf;
  end

  AST_OVF_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $stable(rxBuf)); // R8
  AST_RX_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.done && !rxFull) |=> rxFull); // R7
  AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !dataWrEn) |=> txEmpty); // R7
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (txEmpty && !rxFull && !overflow)); // R11
endmodule

// File: rtl/spiDualWidth.sv
`timescale 1ns/1ps
module spiDualWidth
  import spiPortPkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int WIDE_W = 16,
  parameter int NARROW_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              busAddr,
  input  logic [WIDE_W-1:0] busWrData,
  output logic [WIDE_W-1:0] busRdData,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdoOe,
  input  logic              ssN
);
  spiStrobe_t strobe;
  logic rxBit, txEmpty;
  logic [CTL_BITS-1:0] ctlBits;
  logic ctlWrEn, dataWrEn, dataRdEn;

  assign ctlWrEn  = busWrEn && busAddr;
  assign dataWrEn = busWrEn && !busAddr;
  assign dataRdEn = busRdEn && !busAddr;

  spiCtrl #(.CLK_DIV(CLK_DIV), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W),
            .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(busWrData[CTL_BITS-1:0]),
    .txEmpty(txEmpty), .sckIn(sckIn), .sdi(sdi), .ssN(ssN),
    .strobe(strobe), .rxBit(rxBit), .sckOut(sckOut), .sckOe(sckOe),
    .sdoOe(sdoOe), .ctlBits(ctlBits)
  );

  spiDatapath #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxBit(rxBit), .ctlBits(ctlBits),
    .dataWrEn(dataWrEn), .dataRdEn(dataRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .sdo(sdo), .txEmpty(txEmpty)
  );

  AST_MODE0_SDO: assert property (@(posedge clk) disable iff (!rstN)
    (sckOe && $rose(sckOut)) |-> $stable(sdo)); // R5
endmodule

// File: tb/spiDualWidth_test.sv
`timescale 1ns/1ps
module spiDualWidth_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0, busAddr = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic sckIn = 1'b0, sdi = 1'b0, ssN = 1'b1;
  logic sckOut, sckOe, sdo, sdoOe;

  always #4 clk = ~clk;

  spiDualWidth #(.CLK_DIV(4)) uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .sckIn(sckIn), .sckOut(sckOut),
    .sckOe(sckOe), .sdi(sdi), .sdo(sdo), .sdoOe(sdoOe), .ssN(ssN)
  );

  int checkCnt = 0;
  int failCnt = 0;

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
  endtask

  // scoreboard of expected serial output words
  int expWordQ[$];
  int expLenQ[$];
  logic benchMaster = 1'b0;
  logic monEnable = 1'b1;
  int monCnt = 0;
  int monWord = 0;
  logic sckMon;
  assign sckMon = benchMaster ? sckOut : sckIn;

  always @(posedge sckMon) begin
    if (monEnable) begin
      monWord = (monWord << 1) | int'(sdo);
      monCnt++;
      if (expLenQ.size() > 0 && monCnt == expLenQ[0]) begin
        int w, l;
        w = expWordQ.pop_front();
        l = expLenQ.pop_front();
        checkEq("R2", $sformatf("serial word (%0d bits)", l), monWord & ((1 << l) - 1), w);
        monCnt = 0;
        monWord = 0;
      end
    end
  end

  // remote slave model used while the design is master
  int slvWord = 0;
  int slvLen = 8;
  always @(negedge sckOut) begin
    if (benchMaster) begin
      slvWord = slvWord << 1;
      sdi = ((slvWord >> (slvLen - 1)) & 1) != 0;
    end
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic addr, input logic [15:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = addr; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic addr, output logic [15:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = addr;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic waitRxFull();
    logic [15:0] s;
    for (int i = 0; i < 400; i++) begin
      busRead(1'b1, s);
      if (s[8]) break;
    end
  endtask

  task automatic masterXfer(input int tx, input int slv, input int len);
    benchMaster = 1'b1;
    slvWord = slv;
    slvLen = len;
    sdi = ((slv >> (len - 1)) & 1) != 0;
    expWordQ.push_back(tx & ((1 << len) - 1));
    expLenQ.push_back(len);
    busWrite(1'b0, 16'(tx));
  endtask

  task automatic clockSlave(input logic [15:0] word, input int len);
    for (int i = len - 1; i >= 0; i--) begin
      sdi = word[i];
      waitCycles(6);
      sckIn = 1'b1;
      waitCycles(6);
      sckIn = 1'b0;
    end
    waitCycles(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] s;
    int n;
    waitCycles(4);
    rstN = 1'b1;
    waitCycles(2);

    // R1 reset state
    busRead(1'b1, s);
    checkEq("R1", "status after reset", int'(s), 32'h0200);
    checkEq("R1", "sckOut after reset", int'(sckOut), 0);

    // R4 master role, 8-bit
    busWrite(1'b1, 16'h0001);
    checkEq("R4", "sckOe in master role", int'(sckOe), 1);
    masterXfer(32'h12A5, 32'h3C, 8);
    @(posedge sckOut);
    n = 0;
    @(negedge clk);
    while (sckOut) begin
      n++;
      @(negedge clk);
    end
    checkEq("R4", "clock high cycles", n, 2);
    waitRxFull();
    waitCycles(2);
    busRead(1'b1, s);
    checkEq("R7", "status after 8-bit word", int'(s), 32'h0301);
    busRead(1'b0, s);
    checkEq("R6", "8-bit received word via data address", int'(s), 32'h003C);
    checkEq("R3", "no extra pulses after 8-bit word", monCnt, 0);
    busRead(1'b1, s);
    checkEq("R7", "status after data read", int'(s), 32'h0201);

    // R3 16-bit master
    busWrite(1'b1, 16'h0005);
    masterXfer(32'hBEEF, 32'h1234, 16);
    waitRxFull();
    waitCycles(2);
    busRead(1'b0, s);
    checkEq("R3", "16-bit received word", int'(s), 32'h1234);
    checkEq("R3", "no extra pulses after 16-bit word", monCnt, 0);

    // R8 overflow
    busWrite(1'b1, 16'h0001);
    masterXfer(32'h11, 32'h55, 8);
    waitRxFull();
    masterXfer(32'h22, 32'h77, 8);
    waitCycles(120);
    busRead(1'b1, s);
    checkEq("R8", "status with overflow", int'(s), 32'h0701);
    busRead(1'b0, s);
    checkEq("R8", "buffer keeps first word", int'(s), 32'h0055);
    busRead(1'b1, s);
    checkEq("R7", "read clears full and overflow", int'(s), 32'h0201);

    // R10 slave, select disabled, ssN held high
    benchMaster = 1'b0;
    ssN = 1'b1;
    busWrite(1'b1, 16'h0000);
    waitCycles(4);
    checkEq("R4", "sckOe in slave role", int'(sckOe), 0);
    checkEq("R10", "sdoOe with select disabled", int'(sdoOe), 1);
    expWordQ.push_back(32'hC3);
    expLenQ.push_back(8);
    busWrite(1'b0, 16'h00C3);
    waitCycles(4);
    clockSlave(16'h0096, 8);
    busRead(1'b0, s);
    checkEq("R10", "slave word received ignoring ssN", int'(s), 32'h0096);

    // R9 slave with select enabled
    busWrite(1'b1, 16'h0002);
    waitCycles(4);
    checkEq("R9", "sdoOe off while deselected", int'(sdoOe), 0);
    busWrite(1'b0, 16'h005A);
    monEnable = 1'b0;
    clockSlave(16'h00FF, 8);
    busRead(1'b1, s);
    checkEq("R9", "status after deselected pulses", int'(s), 32'h0002);
    ssN = 1'b0;
    waitCycles(6);
    checkEq("R9", "sdoOe on while selected", int'(sdoOe), 1);
    monCnt = 0;
    monWord = 0;
    monEnable = 1'b1;
    expWordQ.push_back(32'h5A);
    expLenQ.push_back(8);
    clockSlave(16'h0081, 8);
    busRead(1'b0, s);
    checkEq("R9", "selected slave word", int'(s), 32'h0081);

    // R11 word-length change mid-word
    busWrite(1'b0, 16'h000F);
    waitCycles(4);
    monEnable = 1'b0;
    clockSlave(16'h0005, 3);
    busWrite(1'b1, 16'h0006);
    waitCycles(2);
    busRead(1'b1, s);
    checkEq("R11", "status after width change", int'(s), 32'h0206);
    monCnt = 0;
    monWord = 0;
    monEnable = 1'b1;
    expWordQ.push_back(32'hA5C3);
    expLenQ.push_back(16);
    busWrite(1'b0, 16'hA5C3);
    waitCycles(4);
    clockSlave(16'h5EED, 16);
    busRead(1'b0, s);
    checkEq("R11", "full word after width change", int'(s), 32'h5EED);
    checkEq("R2", "scoreboard drained", expWordQ.size(), 0);
    checkEq("R3", "no partial word pending", monCnt, 0);

    summary();
    $finish;
  end
endmodule